// File: doc/BRIEF.md
# GPIO Interrupt Bank

This block controls one bank of up to 32 general-purpose pins through a flat 32-bit register port. Each line is set either to general I/O or to interrupt sensing, and when it is general I/O, either to input or to output. The block holds the output data. It also samples the pads through a two-flop synchronizer, and the synchronized value is what software reads as input data.

A line in interrupt mode raises a status bit. In level mode the bit follows the active level. In edge mode a detected transition latches it until software clears it. Three per-line controls select the behaviour: polarity, edge versus level, and sensing on both edges. An enable vector gates each line onto one combined interrupt request. Lines are disabled by writing zero bits to the mask register and enabled by writing one bits to a separate unmask register. The pad is modelled as three vectors: output enable, output data and input.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, pad_oe is 0 and irq_out is 0. This includes the enable vector, so all lines are disabled.
- R2: Six registers read back what was last written to them, with bits at or above NUM_LINES reading 0: mode at byte offset 0x00 (1 = interrupt), direction at 0x04 (1 = output), output data at 0x08, polarity at 0x20, edge select at 0x24 and both-edge at 0x4C.
- R3: pad_out equals the output data register. pad_oe of a line is 1 only when its direction bit is 1 and its mode bit is 0.
- R4: Offset 0x0C returns pad_in after two clock edges of synchronization. The value is not yet visible after one edge.
- R5: For an interrupt line in level mode (edge bit 0), the status bit equals the synchronized input XOR the polarity bit, one cycle later. Writes to the clear register do not change it.
- R6: For an interrupt line in edge mode with both-edge 0, polarity 0 latches the status bit on a rising input and polarity 1 latches it on a falling input. The opposite transition does not set it. Once set, the bit stays set.
- R7: For an interrupt line in edge mode with both-edge 1, both rising and falling inputs latch the status bit, whatever the polarity.
- R8: Writing 1 to a bit of the clear register at 0x14 clears that edge-latched status bit. Writing 0 bits leaves the status unchanged.
- R9: Writing the mask register at 0x18 disables each line whose written bit is 0, and its 1 bits have no effect. Writing 1 to a bit at 0x1C enables that line. Reading 0x18 returns 1 for each enabled line.
- R10: The status register at 0x10 shows raw status regardless of enable. irq_out is 1 exactly when some line has both its status bit and its enable bit set.
- R11: A line in general I/O mode (mode bit 0) has status 0, whatever its input, polarity or edge settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 7 | Byte address; accesses with bits 1:0 nonzero are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NUM_LINES | Pad input levels |
| pad_out | output | NUM_LINES | Pad output data |
| pad_oe | output | NUM_LINES | Pad output enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest state to reach is a mixed bank. In it, a latched edge must survive the opposite transition, a clear with zero bits and a clear of a neighbouring line, while lines of other modes sit beside it with active pad levels. The bench configures three edge lines with different polarity and both-edge settings on one bank. It walks the pad vector through a fixed sequence of single-bit transitions and reads the status after each one. The general-I/O lines hold high pad levels throughout, so any leak into their status shows at once.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int MAX_LINES = 32;
    localparam int ADDR_W    = 7;

    typedef logic [MAX_LINES-1:0] lvec_t;

    // Word index = byte offset / 4
    typedef enum logic [4:0] {
        W_MODE   = 5'h00,
        W_DIR    = 5'h01,
        W_DOUT   = 5'h02,
        W_DIN    = 5'h03,
        W_STAT   = 5'h04,
        W_CLR    = 5'h05,
        W_MASK   = 5'h06,
        W_UNMASK = 5'h07,
        W_NEG    = 5'h08,
        W_EDGE   = 5'h09,
        W_BOTH   = 5'h13
    } word_e;

    typedef struct packed {
        lvec_t irq_mode;
        lvec_t dir_out;
        lvec_t dout;
        lvec_t neg;
        lvec_t edg;
        lvec_t both;
    } ctrl_t;

    typedef struct packed {
        logic  wr;
        word_e idx;
        lvec_t data;
    } bus_wr_t;

    function automatic lvec_t line_mask(input int n);
        logic [MAX_LINES:0] m;
        m = ({{MAX_LINES{1'b0}}, 1'b1} << n) - {{MAX_LINES{1'b0}}, 1'b1};
        return m[MAX_LINES-1:0];
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_wr_t bw,
    output ctrl_t   ctrl,
    output lvec_t   en,
    output lvec_t   clr_pulse
);
    localparam lvec_t LMASK = line_mask(NUM_LINES);

    lvec_t wd;
    assign wd = bw.data & LMASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            en   <= '0;
        end else if (bw.wr) begin
            case (bw.idx)
                W_MODE:   ctrl.irq_mode <= wd;
                W_DIR:    ctrl.dir_out  <= wd;
                W_DOUT:   ctrl.dout     <= wd;
                W_NEG:    ctrl.neg      <= wd;
                W_EDGE:   ctrl.edg      <= wd;
                W_BOTH:   ctrl.both     <= wd;
                W_MASK:   en            <= en & wd;
                W_UNMASK: en            <= en | wd;
                default:  ;
            endcase
        end
    end

    assign clr_pulse = (bw.wr && bw.idx == W_CLR) ? wd : '0;
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  lvec_t s,
    input  lvec_t irq_mode,
    input  lvec_t neg,
    input  lvec_t edg,
    input  lvec_t both,
    input  lvec_t clr,
    output lvec_t status
);
    for (genvar i = 0; i < MAX_LINES; i++) begin : g_line
        if (i < NUM_LINES) begin : g_on
            logic prev_q, st_q, rise, fall, hit;

            always_comb begin
                rise = s[i] & ~prev_q;
                fall = ~s[i] & prev_q;
                hit  = both[i] ? (rise | fall) : (neg[i] ? fall : rise);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    st_q   <= 1'b0;
                end else begin
                    prev_q <= s[i];
                    if (!irq_mode[i])
                        st_q <= 1'b0;
                    else if (!edg[i])
                        st_q <= s[i] ^ neg[i];
                    else
                        st_q <= hit | (st_q & ~clr[i]);
                end
            end

            assign status[i] = st_q;
        end else begin : g_off
            assign status[i] = 1'b0;
        end
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic                 irq_out
);
    logic    aligned;
    word_e   idx;
    bus_wr_t bw;
    ctrl_t   ctrl;
    lvec_t   en, clr_pulse, status, s_all, oe_all;
    logic [NUM_LINES-1:0] s_n;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = word_e'(bus_addr[ADDR_W-1:2]);
    assign bw.wr   = bus_wr & aligned;
    assign bw.idx  = idx;
    assign bw.data = bus_wdata;

    gpio_bank_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk(clk), .rst(rst), .bw(bw), .ctrl(ctrl), .en(en), .clr_pulse(clr_pulse)
    );

    gpio_bank_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(s_n)
    );

    assign s_all = lvec_t'(s_n);

    gpio_bank_detect #(.NUM_LINES(NUM_LINES)) u_det (
        .clk(clk), .rst(rst), .s(s_all),
        .irq_mode(ctrl.irq_mode), .neg(ctrl.neg), .edg(ctrl.edg), .both(ctrl.both),
        .clr(clr_pulse), .status(status)
    );

    assign oe_all  = ctrl.dir_out & ~ctrl.irq_mode;
    assign pad_oe  = oe_all[NUM_LINES-1:0];
    assign pad_out = ctrl.dout[NUM_LINES-1:0];
    assign irq_out = |(status & en);

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                W_MODE:  bus_rdata = ctrl.irq_mode;
                W_DIR:   bus_rdata = ctrl.dir_out;
                W_DOUT:  bus_rdata = ctrl.dout;
                W_DIN:   bus_rdata = s_all;
                W_STAT:  bus_rdata = status;
                W_MASK:  bus_rdata = en;
                W_NEG:   bus_rdata = ctrl.neg;
                W_EDGE:  bus_rdata = ctrl.edg;
                W_BOTH:  bus_rdata = ctrl.both;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input logic                 clk,
    input logic                 rst,
    input lvec_t                irq_mode,
    input lvec_t                edg,
    input lvec_t                neg,
    input lvec_t                s,
    input lvec_t                status,
    input lvec_t                en,
    input lvec_t                clr,
    input logic [NUM_LINES-1:0] pad_oe,
    input logic                 irq_out
);
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (en == '0 && status == '0));

    assert_no_drive_irq_line_R3: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & irq_mode[NUM_LINES-1:0]) == '0);

    assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(irq_mode & ~edg)) == $past((s ^ neg) & irq_mode & ~edg)));

    assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status & ~clr & irq_mode & edg) & irq_mode & edg & ~status) == '0));

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (en != '0));

    assert_gpio_no_status_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(irq_mode)) == '0));
endmodule

bind gpio_irq_bank gpio_bank_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk(clk), .rst(rst), .irq_mode(ctrl.irq_mode), .edg(ctrl.edg), .neg(ctrl.neg),
    .s(s_all), .status(status), .en(en), .clr(clr_pulse), .pad_oe(pad_oe), .irq_out(irq_out)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
    localparam int NL = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pad_in = '0;
    logic [NL-1:0] pad_out, pad_oe;
    logic          irq_out;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gpio_irq_bank #(.NUM_LINES(NL)) i_gpio_irq_bank (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    // R2 read-back vectors: address, write data, expected read
    localparam logic [31:0] TV_ADDR [6] = '{32'h04, 32'h08, 32'h20, 32'h24, 32'h4C, 32'h00};
    localparam logic [31:0] TV_WR   [6] = '{32'hFFFF_FF5A, 32'h0000_00C3, 32'h0000_00A5,
                                            32'h0000_0F0F, 32'h1234_003C, 32'h1234_5683};
    localparam logic [31:0] TV_EXP  [6] = '{32'h5A, 32'hC3, 32'hA5, 32'h0F, 32'h3C, 32'h83};

    localparam logic [6:0] A_MODE = 7'h00, A_DIR = 7'h04, A_DIN = 7'h0C, A_STAT = 7'h10,
                           A_CLR = 7'h14, A_MASK = 7'h18, A_UNMASK = 7'h1C, A_NEG = 7'h20,
                           A_EDGE = 7'h24, A_BOTH = 7'h4C;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pad(input logic [NL-1:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        for (int a = 0; a <= 'h4C; a += 4) begin
            rd(7'(a), d);
            chk("R1 reg", d, 32'h0);
        end
        chk("R1 oe", 32'(pad_oe), 32'h0);
        chk("R1 irq", 32'(irq_out), 32'h0);

        // R2 vector walk
        for (int k = 0; k < 6; k++) begin
            wr(TV_ADDR[k][6:0], TV_WR[k]);
            rd(TV_ADDR[k][6:0], d);
            chk("R2 readback", d, TV_EXP[k]);
        end
        // R3 pads: dir 0x5A, mode 0x83, out 0xC3
        chk("R3 oe", 32'(pad_oe), 32'h58);
        chk("R3 out", 32'(pad_out), 32'hC3);
        for (int k = 0; k < 6; k++) wr(TV_ADDR[k][6:0], 32'h0);

        // R4 synchronizer latency
        @(negedge clk) pad_in = 8'hA6;
        @(posedge clk);
        rd(A_DIN, d);
        chk("R4 one edge", d, 32'h0);
        @(posedge clk);
        rd(A_DIN, d);
        chk("R4 two edges", d, 32'hA6);

        // R5 level on line 0 (pad low, active-low)
        wr(A_MODE, 32'h01);
        wr(A_NEG, 32'h01);
        repeat (2) @(posedge clk);
        rd(A_STAT, d);
        chk("R5/R11 level", d, 32'h01);
        wr(A_CLR, 32'h01);
        rd(A_STAT, d);
        chk("R5 clear ignored", d, 32'h01);

        // R9 / R10 mask behaviour
        chk("R10 masked irq", 32'(irq_out), 32'h0);
        wr(A_UNMASK, 32'h01);
        chk("R10 irq on", 32'(irq_out), 32'h1);
        wr(A_MASK, 32'hFE);
        rd(A_MASK, d);
        chk("R9 zero disables", d, 32'h0);
        chk("R9 irq off", 32'(irq_out), 32'h0);
        wr(A_UNMASK, 32'h01);
        wr(A_MASK, 32'hFF);
        rd(A_MASK, d);
        chk("R9 ones no effect", d, 32'h01);
        wr(A_NEG, 32'h00);
        repeat (2) @(posedge clk);
        rd(A_STAT, d);
        chk("R5 polarity flip", d, 32'h0);

        // R6 / R7 edge lines: 1 rising, 2 falling, 3 both
        wr(A_EDGE, 32'h0E);
        wr(A_NEG, 32'h04);
        wr(A_BOTH, 32'h08);
        wr(A_MODE, 32'h0E);
        repeat (3) @(posedge clk);
        rd(A_STAT, d);
        chk("R6 no spurious", d, 32'h0);
        pad(8'hA4);
        rd(A_STAT, d);
        chk("R6 falling on rising line", d, 32'h0);
        pad(8'hA6);
        rd(A_STAT, d);
        chk("R6 rising", d, 32'h02);
        pad(8'hA4);
        rd(A_STAT, d);
        chk("R6 sticky", d, 32'h02);
        pad(8'hA0);
        rd(A_STAT, d);
        chk("R6 falling", d, 32'h06);
        pad(8'hA8);
        rd(A_STAT, d);
        chk("R7 both rise", d, 32'h0E);
        wr(A_CLR, 32'h08);
        rd(A_STAT, d);
        chk("R8 clear one", d, 32'h06);
        pad(8'hA0);
        rd(A_STAT, d);
        chk("R7 both fall", d, 32'h0E);
        wr(A_CLR, 32'h00);
        rd(A_STAT, d);
        chk("R8 zero clear", d, 32'h0E);
        chk("R10 status not enabled", 32'(irq_out), 32'h0);
        wr(A_UNMASK, 32'h04);
        chk("R10 enabled status", 32'(irq_out), 32'h1);
        wr(A_CLR, 32'h0E);
        rd(A_STAT, d);
        chk("R8 clear all", d, 32'h0);
        chk("R10 irq drops", 32'(irq_out), 32'h0);
        pad(8'hA4);
        rd(A_STAT, d);
        chk("R6 rising on falling line", d, 32'h0);

        // R11 direction on interrupt line not driven, general line unaffected
        wr(A_DIR, 32'h03);
        chk("R3 oe mixed", 32'(pad_oe), 32'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule